// File: doc/BRIEF.md
# Tick-Synchronized Register Write Front End

This block sits between a CPU-side register bus and a set of control registers that belong to a slow, tick-driven timekeeping domain. Writes to the time, alarm, prescaler-enable and interrupt-enable registers are not applied at once. Each accepted write is parked in a single staging slot and moved into the live register only at the next sync tick. While that slot is occupied, any further write to a tick-synchronized register is dropped without notice. Software is expected to poll the pending flag, or wait for the done flag, before it issues the next write.

The block also keeps a 16-bit event status register. Its write-one-to-clear accesses take effect on the next clock edge and never go through the staging slot. Events from the counter datapath set their status bits whether or not the matching enable is on. The interrupt line is the OR of all status bits that are also enabled. When the prescaler enable is off, commits use the fast oscillator tick instead of the once-per-second tick.

Top module: `slowreg_sync`

## Requirements
- R1: A write to a synchronized register (address 0 time, 1 alarm, 2 prescaler enable in bit 0, 3 interrupt enable in bits 15:0) is stored in the live register on the first selected tick edge after the write is accepted. Until then, reads of that address return the previously committed value.
- R2: A write to any synchronized address that arrives while a write is pending is discarded. Once the pending write has committed, the next write is accepted.
- R3: Status bit 14 (address 4) reads 1 from the edge that accepts a write until the commit edge. Bit 15 sets on the commit edge, which is the same edge on which bit 14 clears.
- R4: Event input bit i (0 stopwatch, 1 alarm, 2 second, 3 minute, 4 hour, 5 day rollover, 6 day alarm) sets status bit i on the next edge.
- R5: A write to address 4 clears every status bit whose write-data bit is 1, on the next edge, and does not set the pending flag.
- R6: Status bits latch their events even when the matching interrupt-enable bit is 0. In that case the interrupt output stays low.
- R7: The interrupt output is a register that goes high one cycle after some status bit and its enable bit at the same position are both 1. It goes low one cycle after no such pair remains.
- R8: When committed prescaler-enable bit 0 is 1, only `tick_slow` commits a pending write. When it is 0, only `tick_fast` does.
- R9: Reset clears all committed registers, all status bits, the pending flag and the interrupt output. After reset the prescaler enable reads 0.
- R10: When an event and a clearing write to the same status bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on the next edge |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tick_slow | input | 1 | One-cycle pulse at the once-per-second rate |
| tick_fast | input | 1 | One-cycle pulse at the oscillator rate |
| evt | input | N_EVT | Event pulses from the counter datapath |
| irq | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle. The live time register changes only after a commit. The staged data holds still whenever a write lands during a pending commit. The pending flag never falls without the done flag rising. A status clear never raises the pending flag. The interrupt is never high unless some enable was set. Other behaviour depends on sequences and is shown only by the bench's scenarios: the choice of tick by the prescaler bit, the exact value a discarded write leaves behind, the set-over-clear priority, and the bit positions of each event.

// File: rtl/slowreg_pkg.sv
package slowreg_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int ST_W      = 16;
  localparam int N_EVT     = 7;
  localparam int NSYNC     = 4;
  // address map
  localparam int ADR_TIME  = 0;
  localparam int ADR_ALARM = 1;
  localparam int ADR_PREN  = 2;
  localparam int ADR_INTEN = 3;
  localparam int ADR_STAT  = 4;
  // status bit positions
  localparam int BIT_PEND  = 14;
  localparam int BIT_WDONE = 15;
endpackage

// File: rtl/slowreg_stage.sv
module slowreg_stage #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              pend,
  output logic              commit,
  output logic [ADDR_W-1:0] stg_addr,
  output logic [DATA_W-1:0] stg_data
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      stg_addr <= '0;
      stg_data <= '0;
    end else if (!pend_q && wr_req) begin
      pend_q   <= 1'b1;
      stg_addr <= wr_addr;
      stg_data <= wr_data;
    end else if (pend_q && tick) begin
      pend_q   <= 1'b0;
    end
  end

  assign pend   = pend_q;
  assign commit = pend_q & tick;
endmodule

// File: rtl/slowreg_bank.sv
module slowreg_bank #(
  parameter int NSYNC  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int ST_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit,
  input  logic [ADDR_W-1:0]             stg_addr,
  input  logic [DATA_W-1:0]             stg_data,
  output logic [NSYNC-1:0][DATA_W-1:0]  val
);
  import slowreg_pkg::*;

  function automatic logic [DATA_W-1:0] keep_mask(input int idx);
    if (idx == ADR_PREN)       return DATA_W'(1);
    else if (idx == ADR_INTEN) return (DATA_W'(1) << ST_W) - DATA_W'(1);
    else                       return '1;
  endfunction

  for (genvar g = 0; g < NSYNC; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)
        r_q <= '0;
      else if (commit && stg_addr == ADDR_W'(g))
        r_q <= stg_data & keep_mask(g);
    end
    assign val[g] = r_q;
  end
endmodule

// File: rtl/slowreg_status.sv
module slowreg_status #(
  parameter int ST_W  = 16,
  parameter int N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt,
  input  logic             clr_we,
  input  logic [ST_W-1:0]  clr_mask,
  input  logic             commit,
  input  logic             pend,
  input  logic [ST_W-1:0]  int_en,
  output logic [ST_W-1:0]  status,
  output logic             irq
);
  import slowreg_pkg::*;

  logic [ST_W-1:0] st_q, st_nxt, clr;

  assign clr = clr_we ? clr_mask : '0;

  always_comb begin
    st_nxt = '0;
    for (int i = 0; i < N_EVT; i++)
      st_nxt[i] = (st_q[i] & ~clr[i]) | evt[i];
    st_nxt[BIT_WDONE] = (st_q[BIT_WDONE] & ~clr[BIT_WDONE]) | commit;
  end

  assign status = st_q | (ST_W'(pend) << BIT_PEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_nxt;
      irq  <= |(status & int_en);
    end
  end
endmodule

// File: rtl/slowreg_sync.sv
module slowreg_sync
  import slowreg_pkg::*;
#(
  parameter int DW = slowreg_pkg::DATA_W,
  parameter int AW = slowreg_pkg::ADDR_W,
  parameter int SW = slowreg_pkg::ST_W,
  parameter int NE = slowreg_pkg::N_EVT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic [NE-1:0] evt,
  output logic          irq
);
  logic                    wr_sync, wr_stat, tick, pend, commit, pren, wdone;
  logic [AW-1:0]           stg_addr;
  logic [DW-1:0]           stg_data, time_val;
  logic [SW-1:0]           int_en, status;
  logic [NSYNC-1:0][DW-1:0] bank_val;

  assign wr_sync = bus_wr && (bus_addr < AW'(NSYNC));
  assign wr_stat = bus_wr && (bus_addr == AW'(ADR_STAT));
  assign pren    = bank_val[ADR_PREN][0];
  assign tick    = pren ? tick_slow : tick_fast;
  assign int_en  = bank_val[ADR_INTEN][SW-1:0];
  assign time_val = bank_val[ADR_TIME];
  assign wdone   = status[BIT_WDONE];

  slowreg_stage #(.DATA_W(DW), .ADDR_W(AW)) u_stage (
    .clk(clk), .rst(rst), .wr_req(wr_sync), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .tick(tick), .pend(pend), .commit(commit),
    .stg_addr(stg_addr), .stg_data(stg_data)
  );

  slowreg_bank #(.NSYNC(NSYNC), .DATA_W(DW), .ADDR_W(AW), .ST_W(SW)) u_bank (
    .clk(clk), .rst(rst), .commit(commit), .stg_addr(stg_addr),
    .stg_data(stg_data), .val(bank_val)
  );

  slowreg_status #(.ST_W(SW), .N_EVT(NE)) u_status (
    .clk(clk), .rst(rst), .evt(evt), .clr_we(wr_stat),
    .clr_mask(bus_wdata[SW-1:0]), .commit(commit), .pend(pend),
    .int_en(int_en), .status(status), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd) begin
      if (bus_addr < AW'(NSYNC))
        bus_rdata <= bank_val[bus_addr[$clog2(NSYNC)-1:0]];
      else if (bus_addr == AW'(ADR_STAT))
        bus_rdata <= DW'(status);
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/slowreg_chk.sv
module slowreg_chk #(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_sync,
  input logic          wr_stat,
  input logic          pend,
  input logic          commit,
  input logic          wdone,
  input logic [DW-1:0] stg_data,
  input logic [DW-1:0] time_val,
  input logic [SW-1:0] int_en,
  input logic          irq
);
  // R1
  time_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (time_val != $past(time_val)) |-> $past(commit));
  // R2
  drop_while_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && wr_sync) |=> $stable(stg_data));
  // R3
  done_with_pend_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> wdone);
  // R3
  commit_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !pend);
  // R5
  clear_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !pend) |=> !pend);
  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(int_en != '0));
endmodule

bind slowreg_sync slowreg_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .wr_sync(wr_sync), .wr_stat(wr_stat), .pend(pend),
  .commit(commit), .wdone(wdone), .stg_data(stg_data), .time_val(time_val),
  .int_en(int_en), .irq(irq)
);

// File: tb/sim_slowreg_sync.sv
`timescale 1ns/1ps
module sim_slowreg_sync;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int NE = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tick_slow = 1'b0, tick_fast = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_q = 1'b0;

  always #4 clk = ~clk;

  slowreg_sync u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .evt(evt), .irq(irq)
  );

  always @(posedge clk) rd_q <= bus_rd;

  // monitor: compare read results with scoreboard entries
  always @(negedge clk) begin
    if (rd_q) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        failures++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string t);
    bus_rd = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_fast();
    tick_fast = 1'b1; @(negedge clk); tick_fast = 1'b0;
  endtask

  task automatic pulse_slow();
    tick_slow = 1'b1; @(negedge clk); tick_slow = 1'b0;
  endtask

  task automatic event_pulse(input logic [NE-1:0] v);
    evt = v; @(negedge clk); evt = '0;
  endtask

  task automatic check_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R9 reset state
    rd(0, 0, "R9 time"); rd(1, 0, "R9 alarm"); rd(2, 0, "R9 prescaler");
    rd(3, 0, "R9 inten"); rd(4, 0, "R9 status");
    check_irq(1'b0, "R9 irq");

    // R1 / R3 / R8 with prescaler off
    wr(0, 32'h0000_1234);
    rd(4, 32'h4000, "R3 pending set");
    rd(0, 0, "R1 uncommitted read");
    pulse_slow();
    rd(0, 0, "R8 slow tick ignored with prescaler off");
    pulse_fast();
    rd(0, 32'h0000_1234, "R1 committed read");
    rd(4, 32'h8000, "R3 done set pending clear");

    // R5 immediate clear
    wr(4, 32'h8000);
    rd(4, 0, "R5 clear immediate no pending");

    // R2 discard during pending
    wr(1, 32'hAA);
    wr(1, 32'hBB);
    pulse_fast();
    rd(1, 32'hAA, "R2 second write dropped");
    wr(4, 32'hFFFF);
    wr(1, 32'hCC);
    pulse_fast();
    rd(1, 32'hCC, "R2 write accepted after commit");
    wr(4, 32'hFFFF);

    // R6 / R4 latching without enable
    event_pulse(7'h7F);
    rd(4, 32'h007F, "R6 all events latch");
    @(negedge clk);
    check_irq(1'b0, "R6 irq low without enable");
    wr(4, 32'hFFFF);
    event_pulse(7'h04);
    rd(4, 32'h0004, "R4 second event bit 2");
    wr(4, 32'hFFFF);
    event_pulse(7'h40);
    rd(4, 32'h0040, "R4 day alarm bit 6");
    wr(4, 32'hFFFF);
    event_pulse(7'h04);

    // R7 irq follows status & enable
    wr(3, 32'h0004);
    pulse_fast();
    @(negedge clk);
    check_irq(1'b1, "R7 irq high");
    wr(4, 32'h0004);
    @(negedge clk);
    check_irq(1'b0, "R7 irq low after clear");
    wr(4, 32'hFFFF);

    // R10 event wins over same-cycle clear
    bus_wr = 1'b1; bus_addr = AW'(4); bus_wdata = 32'h0002; evt = 7'h02;
    @(negedge clk);
    bus_wr = 1'b0; evt = '0;
    rd(4, 32'h0002, "R10 set beats clear");
    wr(4, 32'hFFFF);

    // R8 prescaler on selects slow tick
    wr(2, 32'hFFFF_FFFF);
    pulse_fast();
    rd(2, 32'h1, "R8 prescaler committed bit0 only");
    wr(4, 32'hFFFF);
    wr(0, 32'h55);
    pulse_fast();
    rd(0, 32'h0000_1234, "R8 fast tick ignored with prescaler on");
    rd(4, 32'h4000, "R8 still pending");
    pulse_slow();
    rd(0, 32'h55, "R8 slow tick commits");
    rd(4, 32'h8000, "R3 done after slow commit");

    // R9 reset mid-run
    do_reset();
    rd(2, 0, "R9 prescaler after reset");
    rd(0, 0, "R9 time after reset");
    rd(4, 0, "R9 status after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule